// File: doc/BRIEF.md
# Bidirectional LCD Row Scan Driver

This block drives the row (common) electrodes of a passive LCD panel. A single select bit travels along a chain of row stages, moving one position each time the line-pulse input falls. The row that holds the bit is the selected row. Every other row is non-selected. For each row the block produces a 2-bit drive-level code that an analog stage outside the block turns into one of four panel voltages. The code depends on the row's select state, the frame polarity and an active-low display-off input.

The chain can run in either direction. The direction input decides which end pin takes in the scan bit and which end pin passes on the bit leaving the last stage, so several devices can be chained. Both end pins are bidirectional. The side that is not the input is driven by the block, and the input side is left undriven. Line-pulse falls are found by a two-state machine running on the system clock. In state `LP_WAIT_HIGH` it waits for the line pulse to be seen high, then takes transition `T_SEEN_HIGH` to `LP_ARMED`. In `LP_ARMED`, the line pulse being seen low takes transition `T_FALL`: one shift is issued and the machine returns to `LP_WAIT_HIGH`. Reset enters `LP_WAIT_HIGH`.

Top module: `row_scan_driver`

## Requirements
- R1: After reset every stage of the chain holds 0, so every row is non-selected. With display-off inactive and frame polarity low, every row code reads 01.
- R2: Exactly one shift happens for each high-to-low transition of `lp`, in the clock edge where `lp` is first sampled low. `lp` held high or held low for any number of cycles causes no further shift.
- R3: With `dir` = 0 the bit on `end_a` enters row 0 and each row takes the value of its lower neighbour. `end_b` is driven with the value of row ROWS-1.
- R4: With `dir` = 1 the bit on `end_b` enters row ROWS-1 and each row takes the value of its upper neighbour. `end_a` is driven with the value of row 0.
- R5: The cascade output pin follows the current value of the stage at the output end, so a bit shifted in appears on that pin after exactly ROWS shifts.
- R6: With `disp_off_n` low every row code is 00 (Vss), whatever the chain holds.
- R7: With `disp_off_n` high, a selected row (stage = 1) gives code 11 (V0) when `fr` = 1 and code 00 (Vss) when `fr` = 0.
- R8: With `disp_off_n` high, a non-selected row (stage = 0) gives code 10 (V43) when `fr` = 1 and code 01 (V12) when `fr` = 0.
- R9: Row r's code is at bits [2r+1:2r] of `row_lvl`. Codes react to `fr` and `disp_off_n` in the same cycle, with no clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp | input | 1 | Line pulse; the chain shifts on each falling transition |
| dir | input | 1 | Shift direction: 0 means end_a to end_b, 1 means end_b to end_a |
| fr | input | 1 | Frame polarity |
| disp_off_n | input | 1 | Active-low display-off; forces every row to Vss |
| end_a | inout | 1 | Scan input when dir = 0, cascade output when dir = 1 |
| end_b | inout | 1 | Cascade output when dir = 0, scan input when dir = 1 |
| row_lvl | output | 2*ROWS | Per-row drive code: 00 Vss, 01 V12, 10 V43, 11 V0 |

## Verification
The bench holds `lp` high and low for several cycles to catch a design that shifts on a level instead of a transition, or shifts twice per pulse. It walks a bit through all 240 stages in both directions and watches the far pin. A design with a swapped or off-by-one end stage would show the bit one shift early or late, or on the wrong pin. It reverses the direction while the chain holds a pattern, which exposes a design whose neighbour indexing is the same in both directions. Random mixes of frame polarity and display-off compare every row code, so any swapped entry in the four-level table shows up at once.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

    typedef enum logic [1:0] {
        LVL_VSS = 2'b00,
        LVL_V12 = 2'b01,
        LVL_V43 = 2'b10,
        LVL_V0  = 2'b11
    } drive_lvl_t;

    typedef enum logic {
        LP_WAIT_HIGH = 1'b0,
        LP_ARMED     = 1'b1
    } lp_state_t;

endpackage

// File: rtl/lp_fall_fsm.sv
module lp_fall_fsm
    import row_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lp,
    output logic shift_pulse
);

    lp_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LP_WAIT_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        shift_pulse = 1'b0;
        unique case (state_q)
            LP_WAIT_HIGH: if (lp)  state_d = LP_ARMED;      // T_SEEN_HIGH
            LP_ARMED: if (!lp) begin                        // T_FALL
                state_d     = LP_WAIT_HIGH;
                shift_pulse = 1'b1;
            end
            default: state_d = LP_WAIT_HIGH;
        endcase
    end

    AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |-> (!lp && $past(lp)));                               // R2
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse);                                     // R2

endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
    parameter int ROWS = 240
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            dir,
    input  logic            din_a,
    input  logic            din_b,
    output logic [ROWS-1:0] stage_q
);

    localparam int LAST = ROWS - 1;

    logic [ROWS-1:0] stage_d;

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_stage
            logic from_low, from_high;
            if (r == 0) begin : g_low_end
                assign from_low = din_a;
            end else begin : g_low_mid
                assign from_low = stage_q[r-1];
            end
            if (r == LAST) begin : g_high_end
                assign from_high = din_b;
            end else begin : g_high_mid
                assign from_high = stage_q[r+1];
            end
            assign stage_d[r] = dir ? from_high : from_low;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stage_q <= '0;
        else if (shift_en) stage_q <= stage_d;
    end

    AST_HOLD_WITHOUT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(stage_q));                                   // R2
    AST_ENTRY_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !dir) |=> (stage_q[0] == $past(din_a)));              // R3
    AST_ENTRY_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && dir) |=> (stage_q[LAST] == $past(din_b)));            // R4

endmodule

// File: rtl/level_encoder.sv
module level_encoder
    import row_scan_pkg::*;
#(
    parameter int ROWS = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROWS-1:0]   sel,
    input  logic              fr,
    input  logic              disp_off_n,
    output logic [2*ROWS-1:0] lvl
);

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            drive_lvl_t code;
            always_comb begin
                if (!disp_off_n)  code = LVL_VSS;
                else if (sel[r])  code = fr ? LVL_V0  : LVL_VSS;
                else              code = fr ? LVL_V43 : LVL_V12;
            end
            assign lvl[2*r +: 2] = code;
        end
    endgenerate

    AST_DISPOFF_ALL_VSS: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_off_n |-> (lvl == '0));                                      // R6
    AST_ROW0_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_off_n && sel[0]) |-> (lvl[1:0] == {fr, fr}));                // R7
    AST_ROW0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_off_n && !sel[0]) |-> (lvl[1:0] == {fr, !fr}));              // R8

endmodule

// File: rtl/row_scan_driver.sv
module row_scan_driver
    import row_scan_pkg::*;
#(
    parameter int ROWS = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp,
    input  logic              dir,
    input  logic              fr,
    input  logic              disp_off_n,
    inout  wire               end_a,
    inout  wire               end_b,
    output logic [2*ROWS-1:0] row_lvl
);

    localparam int LAST = ROWS - 1;

    logic            shift_pulse;
    logic [ROWS-1:0] stage_q;

    lp_fall_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lp          (lp),
        .shift_pulse (shift_pulse)
    );

    scan_chain #(.ROWS(ROWS)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_pulse),
        .dir      (dir),
        .din_a    (end_a),
        .din_b    (end_b),
        .stage_q  (stage_q)
    );

    level_encoder #(.ROWS(ROWS)) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (stage_q),
        .fr         (fr),
        .disp_off_n (disp_off_n),
        .lvl        (row_lvl)
    );

    assign end_a = dir ? stage_q[0]    : 1'bz;
    assign end_b = dir ? 1'bz          : stage_q[LAST];

    AST_CASCADE_B: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |-> (end_b == stage_q[LAST]));                                // R5
    AST_CASCADE_A: assert property (@(posedge clk) disable iff (!rst_n)
        dir |-> (end_a == stage_q[0]));                                    // R5

endmodule

// File: tb/row_scan_driver_test.sv
module row_scan_driver_test;

    localparam int ROWS = 240;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp = 1'b0, dir = 1'b0, fr = 1'b0, disp_off_n = 1'b1;
    logic tb_din = 1'b0;
    wire  end_a, end_b;
    logic [2*ROWS-1:0] row_lvl;

    int checks = 0, fails = 0;
    logic [ROWS-1:0] model;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign end_a = dir ? 1'bz : tb_din;
    assign end_b = dir ? tb_din : 1'bz;

    row_scan_driver #(.ROWS(ROWS)) uut (
        .clk(clk), .rst_n(rst_n), .lp(lp), .dir(dir), .fr(fr),
        .disp_off_n(disp_off_n), .end_a(end_a), .end_b(end_b), .row_lvl(row_lvl)
    );

    function automatic logic [1:0] exp_code(logic s, logic f, logic on_n);
        if (!on_n) return 2'b00;
        if (s)     return f ? 2'b11 : 2'b00;
        return f ? 2'b10 : 2'b01;
    endfunction

    task automatic check_rows(string req);
        int bad = -1;
        logic [1:0] got, exp;
        checks++;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (row_lvl[2*r +: 2] !== exp_code(model[r], fr, disp_off_n)) begin
                bad = r;
                got = row_lvl[2*r +: 2];
                exp = exp_code(model[r], fr, disp_off_n);
            end
        end
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s row %0d code actual=%b expected=%b", req, bad, got, exp);
        end
    endtask

    task automatic check_pin(string req);
        logic got, exp;
        checks++;
        got = dir ? end_a : end_b;
        exp = dir ? model[0] : model[ROWS-1];
        if (got !== exp) begin
            fails++;
            $display("FAIL %s cascade pin actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic model_shift(logic bitin);
        if (!dir) model = {model[ROWS-2:0], bitin};
        else      model = {bitin, model[ROWS-1:1]};
    endtask

    // one lp pulse; hold_hi/hold_lo cycles at each level; sampled at negedge
    task automatic pulse(logic bitin, int hold_hi, int hold_lo);
        tb_din = bitin;
        lp = 1'b1;
        repeat (hold_hi) @(negedge clk);
        lp = 1'b0;
        @(negedge clk);
        model_shift(bitin);
        repeat (hold_lo - 1) @(negedge clk);
    endtask

    initial begin
        model = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_rows("R1");
        check_pin("R1");

        // R2: long high and long low give exactly one shift
        pulse(1'b1, 6, 6);
        check_rows("R2");
        pulse(1'b0, 1, 1);
        check_rows("R2");
        lp = 1'b0;
        repeat (5) @(negedge clk);
        check_rows("R2");

        // R3/R5: walk the bit to the far end forward
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; model = '0; dir = 1'b0;
        fr = 1'b1;
        pulse(1'b1, 1, 1);
        check_rows("R3");
        for (int i = 1; i < ROWS; i++) pulse(1'b0, 1, 1);
        check_rows("R3");
        check_pin("R5");
        pulse(1'b0, 1, 1);
        check_pin("R5");

        // R4/R5: reverse
        dir = 1'b1;
        pulse(1'b1, 1, 1);
        check_rows("R4");
        for (int i = 1; i < ROWS; i++) pulse(1'b0, 1, 1);
        check_rows("R4");
        check_pin("R5");

        // R6/R7/R8/R9: codes react combinationally
        pulse(1'b1, 1, 1);
        fr = 1'b0; #1; check_rows("R7");
        fr = 1'b1; #1; check_rows("R8");
        disp_off_n = 1'b0; #1; check_rows("R6");
        disp_off_n = 1'b1; #1; check_rows("R9");

        // random mix
        void'($urandom(32'h5eed_1234));
        for (int it = 0; it < 400; it++) begin
            dir = $urandom_range(0, 9) == 0 ? ~dir : dir;
            pulse(1'($urandom_range(0, 1)), $urandom_range(1, 3), $urandom_range(1, 3));
            fr = 1'($urandom_range(0, 1));
            disp_off_n = $urandom_range(0, 3) != 0;
            #1;
            check_rows(disp_off_n ? (fr ? "R7/R8 fr=1" : "R7/R8 fr=0") : "R6");
            check_pin(dir ? "R4/R5" : "R3/R5");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule